// File: doc/BRIEF.md
# Receive Frame Length and Destination Screen

This block watches the byte stream coming out of a receive PHY-side adapter, one byte per clock qualified by a data-valid strobe, together with a per-byte receive-error strobe. It counts each frame's bytes, captures the six-byte destination address at the head of the frame, and, when data-valid drops, decides whether the frame is kept and which of the receive channels it is handed to. Frame data is not stored here. A downstream buffer manager uses the verdict to commit or drop what it has collected.

Steering has a fixed priority. A destination equal to the station address goes to the station channel, provided that channel's unicast enable is set. Otherwise an all-ones destination goes to the broadcast channel, and a group address goes to the multicast channel, each only when its mode is enabled. Anything else is taken by the promiscuous channel when that mode is on. Frames that are too short, too long or carry a coding error are dropped. The exception is promiscuous mode with its keep-bad option set: it takes every bad frame.

Top module: `rx_frame_screen`

## Requirements
- R1: A frame of fewer than 64 bytes (all bytes while data-valid is high) raises `flag_runt` in its verdict. A frame of exactly 64 bytes does not.
- R2: A frame whose byte count is larger than `max_len` raises `flag_oversize`. A count equal to `max_len` does not.
- R3: A good frame of at least 6 bytes is accepted on `stn_chan` when its first six bytes equal `station_addr` and `ucast_en[stn_chan]` is 1. The first byte compares with `station_addr[47:40]` and the sixth with `station_addr[7:0]`. When that enable bit is 0, the match does not count.
- R4: A good frame whose six destination bytes are all 8'hFF is accepted on `bcast_chan` when `bcast_en` is 1 and no unicast match applies.
- R5: A good frame whose first byte has bit 0 set and which is not broadcast is accepted on `mcast_chan` when `mcast_en` is 1 and no unicast match applies.
- R6: A good frame that none of R3 to R5 accepts is accepted on `promisc_chan` when `promisc_en` is 1, and rejected otherwise.
- R7: A bad frame (runt, oversize or coding error) is rejected. When both `promisc_en` and `promisc_keep_bad` are 1, it is instead accepted on `promisc_chan`. The error flags are reported in either case.
- R8: Priority is unicast, then broadcast, then multicast, then promiscuous. An enabled unicast match wins even when promiscuous mode is on, and a broadcast frame goes to `bcast_chan` even when promiscuous mode is on.
- R9: `rx_err` sets `flag_code_err` when it is high in any cycle with `rx_valid` high. While `rx_valid` is low, `rx_err` has no effect.
- R10: `frame_done` is high for exactly one cycle, the cycle after the clock edge at which `rx_valid` is first seen low following a frame. Outside that cycle, `frame_accept`, `frame_chan` and the flags are 0. A rejected verdict carries `frame_chan` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte strobe; a frame is a run of high cycles |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 1 | Coding error on the current byte |
| station_addr | input | 48 | Station unicast address, first byte in [47:40] |
| stn_chan | input | CHW | Channel for station matches |
| ucast_en | input | NCH | Per-channel unicast enable |
| bcast_en | input | 1 | Broadcast mode enable |
| bcast_chan | input | CHW | Broadcast channel |
| mcast_en | input | 1 | Multicast mode enable |
| mcast_chan | input | CHW | Multicast channel |
| promisc_en | input | 1 | Promiscuous mode enable |
| promisc_chan | input | CHW | Promiscuous channel |
| promisc_keep_bad | input | 1 | Promiscuous mode also takes bad frames |
| max_len | input | LW | Largest allowed byte count |
| frame_done | output | 1 | Verdict strobe |
| frame_accept | output | 1 | Frame kept |
| frame_chan | output | CHW | Target channel |
| flag_runt | output | 1 | Frame shorter than 64 bytes |
| flag_oversize | output | 1 | Frame longer than `max_len` |
| flag_code_err | output | 1 | Error seen during the frame |

## Verification
The bench probes the length thresholds on both sides: 63 and 64 bytes, and `max_len` and `max_len`+1. A comparison off by one would flag the legal frame or pass the illegal one. It checks that an `rx_err` pulse between frames does not leak into the next frame's verdict. A design that sampled the error strobe unqualified would report a coding error on a clean frame. It also pits promiscuous mode against unicast and broadcast matches, and checks that a disabled unicast channel hides the match. Wrong priority would show up as the wrong `frame_chan`.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_W   = 48;
  localparam int MIN_LEN  = 64;
  localparam int DEST_LEN = 6;

  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_UCAST   = 3'd1,
    SRC_BCAST   = 3'd2,
    SRC_MCAST   = 3'd3,
    SRC_PROMISC = 3'd4
  } rxf_src_e;

  // All-ones destination.
  function automatic logic f_is_bcast(input logic [ADDR_W-1:0] a);
    return &a;
  endfunction

  // Group bit is bit 0 of the first byte on the wire, held in [40].
  function automatic logic f_is_mcast(input logic [ADDR_W-1:0] a);
    return a[40] && !(&a);
  endfunction

  // Index of the top bit of byte k, with byte 0 first on the wire.
  function automatic int f_lane_hi(input int k);
    return ADDR_W - 1 - 8 * k;
  endfunction
endpackage

// File: rtl/rxf_frame_meter.sv
module rxf_frame_meter #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_err,
  input  logic          in_frame_q,
  input  logic [LW-1:0] max_len,
  output logic [LW-1:0] byte_cnt,
  output logic          is_runt,
  output logic          is_over,
  output logic          saw_err
);
  import rxf_pkg::*;
  localparam logic [LW-1:0] CNT_MAX = '1;
  localparam logic [LW-1:0] RUNT_LIM = LW'(MIN_LEN);

  logic [LW-1:0] cnt_q;
  logic          err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (rx_valid) begin
      if (!in_frame_q) begin
        cnt_q <= LW'(1);
        err_q <= rx_err;
      end else begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + LW'(1);
        err_q <= err_q | rx_err;
      end
    end
  end

  assign byte_cnt = cnt_q;
  assign is_runt  = cnt_q < RUNT_LIM;
  assign is_over  = cnt_q > max_len;
  assign saw_err  = err_q;
endmodule

// File: rtl/rxf_dest_capture.sv
module rxf_dest_capture #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          in_frame_q,
  input  logic [LW-1:0] byte_cnt,
  output logic [47:0]   dest,
  output logic          dest_ok
);
  import rxf_pkg::*;
  logic [LW-1:0] pos;
  logic [47:0]   dest_q;

  assign pos = in_frame_q ? byte_cnt : '0;

  for (genvar k = 0; k < DEST_LEN; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dest_q[f_lane_hi(k) -: 8] <= 8'h00;
      else if (rx_valid && pos == LW'(k))
        dest_q[f_lane_hi(k) -: 8] <= rx_byte;
    end
  end

  assign dest    = dest_q;
  assign dest_ok = byte_cnt >= LW'(DEST_LEN);
endmodule

// File: rtl/rxf_steer.sv
module rxf_steer #(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  logic [47:0]    dest,
  input  logic           dest_ok,
  input  logic           bad,
  input  logic [47:0]    station_addr,
  input  logic [CHW-1:0] stn_chan,
  input  logic [NCH-1:0] ucast_en,
  input  logic           bcast_en,
  input  logic [CHW-1:0] bcast_chan,
  input  logic           mcast_en,
  input  logic [CHW-1:0] mcast_chan,
  input  logic           promisc_en,
  input  logic [CHW-1:0] promisc_chan,
  input  logic           promisc_keep_bad,
  output logic           ucast_hit,
  output rxf_pkg::rxf_src_e src,
  output logic           accept,
  output logic [CHW-1:0] chan
);
  import rxf_pkg::*;
  logic is_b, is_m;

  assign ucast_hit = dest_ok && (dest == station_addr) && ucast_en[stn_chan];
  assign is_b      = dest_ok && f_is_bcast(dest);
  assign is_m      = dest_ok && f_is_mcast(dest);

  always_comb begin
    src = SRC_NONE;
    if (bad) begin
      if (promisc_en && promisc_keep_bad) src = SRC_PROMISC;
    end else if (ucast_hit)          src = SRC_UCAST;
    else if (is_b && bcast_en)       src = SRC_BCAST;
    else if (is_m && mcast_en)       src = SRC_MCAST;
    else if (promisc_en)             src = SRC_PROMISC;
  end

  always_comb begin
    accept = 1'b1;
    chan   = '0;
    case (src)
      SRC_UCAST:   chan = stn_chan;
      SRC_BCAST:   chan = bcast_chan;
      SRC_MCAST:   chan = mcast_chan;
      SRC_PROMISC: chan = promisc_chan;
      default:     accept = 1'b0;
    endcase
  end
endmodule

// File: rtl/rx_frame_screen.sv
module rx_frame_screen #(
  parameter int NCH = 8,
  parameter int LW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_valid,
  input  logic [7:0]     rx_byte,
  input  logic           rx_err,
  input  logic [47:0]    station_addr,
  input  logic [CHW-1:0] stn_chan,
  input  logic [NCH-1:0] ucast_en,
  input  logic           bcast_en,
  input  logic [CHW-1:0] bcast_chan,
  input  logic           mcast_en,
  input  logic [CHW-1:0] mcast_chan,
  input  logic           promisc_en,
  input  logic [CHW-1:0] promisc_chan,
  input  logic           promisc_keep_bad,
  input  logic [LW-1:0]  max_len,
  output logic           frame_done,
  output logic           frame_accept,
  output logic [CHW-1:0] frame_chan,
  output logic           flag_runt,
  output logic           flag_oversize,
  output logic           flag_code_err
);
  import rxf_pkg::*;

  logic          in_frame_q;
  logic          eof_evt;
  logic [LW-1:0] byte_cnt;
  logic          is_runt, is_over, saw_err, bad;
  logic [47:0]   dest;
  logic          dest_ok;
  logic          ucast_hit;
  rxf_src_e      src;
  logic          st_accept;
  logic [CHW-1:0] st_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_frame_q <= 1'b0;
    else        in_frame_q <= rx_valid;
  end

  assign eof_evt = in_frame_q && !rx_valid;
  assign bad     = is_runt | is_over | saw_err;

  rxf_frame_meter #(.LW(LW)) meter_i (
    .clk, .rst_n, .rx_valid, .rx_err, .in_frame_q, .max_len,
    .byte_cnt, .is_runt, .is_over, .saw_err
  );

  rxf_dest_capture #(.LW(LW)) dcap_i (
    .clk, .rst_n, .rx_valid, .rx_byte, .in_frame_q, .byte_cnt,
    .dest, .dest_ok
  );

  rxf_steer #(.NCH(NCH), .CHW(CHW)) steer_i (
    .dest, .dest_ok, .bad, .station_addr, .stn_chan, .ucast_en,
    .bcast_en, .bcast_chan, .mcast_en, .mcast_chan,
    .promisc_en, .promisc_chan, .promisc_keep_bad,
    .ucast_hit, .src, .accept(st_accept), .chan(st_chan)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_done    <= 1'b0;
      frame_accept  <= 1'b0;
      frame_chan    <= '0;
      flag_runt     <= 1'b0;
      flag_oversize <= 1'b0;
      flag_code_err <= 1'b0;
    end else if (eof_evt) begin
      frame_done    <= 1'b1;
      frame_accept  <= st_accept;
      frame_chan    <= st_chan;
      flag_runt     <= is_runt;
      flag_oversize <= is_over;
      flag_code_err <= saw_err;
    end else begin
      frame_done    <= 1'b0;
      frame_accept  <= 1'b0;
      frame_chan    <= '0;
      flag_runt     <= 1'b0;
      flag_oversize <= 1'b0;
      flag_code_err <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_frame_screen_chk.sv
module rx_frame_screen_chk #(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rx_valid,
  input logic           eof_evt,
  input logic           ucast_hit,
  input logic           bad,
  input logic [CHW-1:0] stn_chan,
  input logic           promisc_en,
  input logic           promisc_keep_bad,
  input logic           frame_done,
  input logic           frame_accept,
  input logic [CHW-1:0] frame_chan,
  input logic           flag_runt,
  input logic           flag_oversize,
  input logic           flag_code_err
);
  // R10: the verdict strobe lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10: an end-of-frame event yields a verdict on the next cycle
  a_r10_eof_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    eof_evt |=> frame_done);

  // R10: a verdict follows only a falling data-valid
  a_r10_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !$past(rx_valid));

  // R10: outputs are quiet outside the verdict cycle
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> !frame_accept && frame_chan == '0 &&
                    !flag_runt && !flag_oversize && !flag_code_err);

  // R10: a rejected frame carries channel zero
  a_r10_reject_chan0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_accept |-> frame_chan == '0);

  // R7: an accepted bad frame needs promiscuous keep-bad
  a_r7_bad_needs_keep: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_accept && (flag_runt || flag_oversize || flag_code_err)
      |-> promisc_en && promisc_keep_bad);

  // R8: an enabled station match on a good frame wins
  a_r8_ucast_first: assert property (@(posedge clk) disable iff (!rst_n)
    eof_evt && ucast_hit && !bad |=> frame_accept && frame_chan == $past(stn_chan));
endmodule

bind rx_frame_screen rx_frame_screen_chk #(.NCH(NCH), .CHW(CHW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .eof_evt(eof_evt),
  .ucast_hit(ucast_hit), .bad(bad), .stn_chan(stn_chan),
  .promisc_en(promisc_en), .promisc_keep_bad(promisc_keep_bad),
  .frame_done(frame_done), .frame_accept(frame_accept), .frame_chan(frame_chan),
  .flag_runt(flag_runt), .flag_oversize(flag_oversize), .flag_code_err(flag_code_err)
);

// File: tb/rx_frame_screen_tb_top.sv
module rx_frame_screen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int CHW = 3;
  localparam int LW  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_valid, rx_err;
  logic [7:0] rx_byte;
  logic [47:0] station_addr;
  logic [CHW-1:0] stn_chan, bcast_chan, mcast_chan, promisc_chan;
  logic [NCH-1:0] ucast_en;
  logic bcast_en, mcast_en, promisc_en, promisc_keep_bad;
  logic [LW-1:0] max_len;
  logic frame_done, frame_accept, flag_runt, flag_oversize, flag_code_err;
  logic [CHW-1:0] frame_chan;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_screen #(.NCH(NCH), .LW(LW)) dut_i (
    .clk, .rst_n, .rx_valid, .rx_byte, .rx_err, .station_addr, .stn_chan,
    .ucast_en, .bcast_en, .bcast_chan, .mcast_en, .mcast_chan,
    .promisc_en, .promisc_chan, .promisc_keep_bad, .max_len,
    .frame_done, .frame_accept, .frame_chan, .flag_runt, .flag_oversize,
    .flag_code_err
  );

  localparam logic [47:0] STN   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_07;

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [NCH-1:0] ue, input logic be, input logic me,
                         input logic pe, input logic kb, input int ml);
    ucast_en = ue; bcast_en = be; mcast_en = me; promisc_en = pe;
    promisc_keep_bad = kb; max_len = LW'(ml);
  endtask

  // Independent verdict model written from the requirements.
  task automatic send_check(input string tag, input logic [47:0] dst, input int len,
                            input int err_at);
    logic runt, over, err, bad, hit, isb, ism, acc;
    int ch;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1;
      rx_byte  = (i < 6) ? dst[47 - 8*i -: 8] : 8'(i);
      rx_err   = (i == err_at);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_err = 1'b0; rx_byte = 8'h00;
    @(negedge clk);
    runt = len < 64;
    over = len > int'(max_len);
    err  = (err_at >= 0) && (err_at < len);
    bad  = runt || over || err;
    hit  = (len >= 6) && dst == station_addr && ucast_en[stn_chan];
    isb  = (len >= 6) && dst == BCAST;
    ism  = (len >= 6) && dst[40] && !isb;
    acc = 1'b0; ch = 0;
    if (bad) begin
      if (promisc_en && promisc_keep_bad) begin acc = 1'b1; ch = promisc_chan; end
    end else if (hit)             begin acc = 1'b1; ch = stn_chan; end
    else if (isb && bcast_en)     begin acc = 1'b1; ch = bcast_chan; end
    else if (ism && mcast_en)     begin acc = 1'b1; ch = mcast_chan; end
    else if (promisc_en)          begin acc = 1'b1; ch = promisc_chan; end
    cmp(tag, "done", frame_done, 1);
    cmp(tag, "accept", frame_accept, acc);
    cmp(tag, "chan", frame_chan, ch);
    cmp(tag, "runt", flag_runt, runt);
    cmp(tag, "oversize", flag_oversize, over);
    cmp(tag, "code_err", flag_code_err, err);
    @(negedge clk);
    cmp("R10", "done one cycle", frame_done, 0);
    cmp("R10", "accept quiet", frame_accept, 0);
  endtask

  task automatic t_reset();
    cmp("R10", "reset done", frame_done, 0);
    cmp("R10", "reset accept", frame_accept, 0);
    cmp("R10", "reset chan", frame_chan, 0);
  endtask

  task automatic t_unicast();
    set_cfg(8'h20, 0, 0, 0, 0, 1518);
    send_check("R3", STN, 64, -1);
    set_cfg(8'hDF, 0, 0, 0, 0, 1518);
    send_check("R3", STN, 80, -1);       // enable bit for stn_chan clear
  endtask

  task automatic t_bcast_mcast();
    set_cfg(8'h20, 1, 0, 0, 0, 1518);
    send_check("R4", BCAST, 70, -1);
    set_cfg(8'h20, 0, 0, 0, 0, 1518);
    send_check("R4", BCAST, 70, -1);
    set_cfg(8'h20, 0, 1, 0, 0, 1518);
    send_check("R5", MCAST, 66, -1);
    set_cfg(8'h20, 1, 0, 0, 0, 1518);
    send_check("R5", MCAST, 66, -1);     // multicast off, broadcast on
  endtask

  task automatic t_promisc();
    set_cfg(8'h20, 0, 0, 1, 0, 1518);
    send_check("R6", OTHER, 64, -1);
    set_cfg(8'h20, 0, 0, 0, 0, 1518);
    send_check("R6", OTHER, 64, -1);
  endtask

  task automatic t_lengths();
    set_cfg(8'h20, 0, 0, 0, 0, 1518);
    send_check("R1", STN, 63, -1);
    send_check("R1", STN, 64, -1);
    send_check("R1", STN, 4, -1);
    set_cfg(8'h20, 0, 0, 0, 0, 100);
    send_check("R2", STN, 100, -1);
    send_check("R2", STN, 101, -1);
  endtask

  task automatic t_errors();
    set_cfg(8'h20, 0, 0, 0, 0, 1518);
    send_check("R9", STN, 72, 30);
    send_check("R9", STN, 72, 0);
    rx_err = 1'b1;                       // error with valid low
    repeat (3) @(negedge clk);
    cmp("R9", "no verdict from idle error", frame_done, 0);
    rx_err = 1'b0;
    send_check("R9", STN, 72, -1);
  endtask

  task automatic t_keep_bad();
    set_cfg(8'h20, 0, 0, 1, 1, 1518);
    send_check("R7", OTHER, 40, -1);
    send_check("R7", STN, 90, 50);
    set_cfg(8'h20, 0, 0, 1, 0, 1518);
    send_check("R7", STN, 40, -1);
  endtask

  task automatic t_priority();
    set_cfg(8'h20, 1, 1, 1, 0, 1518);
    send_check("R8", STN, 64, -1);
    send_check("R8", BCAST, 64, -1);
    send_check("R8", MCAST, 64, -1);
    send_check("R8", OTHER, 64, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_err = 1'b0; rx_byte = 8'h00;
    station_addr = STN; stn_chan = 3'd5; bcast_chan = 3'd2;
    mcast_chan = 3'd3; promisc_chan = 3'd6;
    set_cfg(8'h00, 0, 0, 0, 0, 1518);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unicast();
    t_bcast_mcast();
    t_promisc();
    t_lengths();
    t_errors();
    t_keep_bad();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule